// File: doc/BRIEF.md
# Interrupt Source Gateway and Pending Tracker

This block sits between a set of interrupt request lines and a priority selector. It watches every source line, turns it into assertion and release events, and keeps three state bits for each source in each target context: pending, claimed (in service) and one-shot. Level-type sources stay pending while their line is high. Edge-type sources are converted into single events: a rising edge makes the source pending and marks it one-shot, so that a claim removes it completely rather than leaving it in service.

The selector, which is outside this block, picks a winner from the pending and claimed vectors. It then reports the winner back through the claim strobe. The handler later reports the end of service through the completion strobe. Each context has its own enable vector. Clearing an enable bit erases that context's state for the source. Setting an enable bit looks at the current line level again, so a line that is already high becomes pending at once.

Top module: `irq_gateway`

## Requirements
- R1: While reset is high and on the first cycle after it, `pending_o` and `claimed_o` are all zero. Bit `c*NUM_SRC + s` of either vector belongs to source `s` in context `c`.
- R2: A rising level on a level-type source (`src_edge_i[s]=0`) sets pending for that source in every context whose enable bit is set. The bit is visible on the third rising clock edge after the line changes.
- R3: A rising edge on an edge-type source (`src_edge_i[s]=1`) sets pending and marks it one-shot. While the line stays high, the source does not become pending again after it is claimed.
- R4: A falling level on a level-type source clears pending, claimed and one-shot for that source in all contexts. A falling line on an edge-type source changes nothing.
- R5: A claim of a pending source that is not one-shot sets its claimed bit in that context and leaves its pending bit set.
- R6: A claim of a pending one-shot source clears its pending, claimed and one-shot bits in that context.
- R7: A completion strobe clears the claimed bit of that source in that context. The pending bit is not affected.
- R8: An enable bit going from 0 to 1 while the source line is high sets pending at once. For an edge-type source the one-shot mark is set as well.
- R9: While an enable bit is 0, the pending, claimed and one-shot bits of that source in that context are clear, from the next cycle on.
- R10: Source 0 never becomes pending. A claim or completion is ignored if its ID is 0 or at least NUM_SRC, if its context is at least NUM_CTX, or (for a claim) if the source is not pending.
- R11: If a claim and a new edge assertion of the same source reach the tracker in the same cycle, the assertion wins and the source remains pending and one-shot.
- R12: A claimed bit is never set unless the pending bit at the same position is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_SRC | Raw interrupt lines; bit 0 unused |
| src_edge_i | input | NUM_SRC | Per-source type: 1 edge, 0 level |
| enable_i | input | NUM_CTX*NUM_SRC | Enable bits, bit c*NUM_SRC+s |
| claim_valid_i | input | 1 | Claim strobe |
| claim_ctx_i | input | CTX_W | Context of the claim |
| claim_id_i | input | ID_W | Source ID being claimed |
| done_valid_i | input | 1 | Completion strobe |
| done_ctx_i | input | CTX_W | Context of the completion |
| done_id_i | input | ID_W | Source ID being completed |
| pending_o | output | NUM_CTX*NUM_SRC | Registered pending vector |
| claimed_o | output | NUM_CTX*NUM_SRC | Registered in-service vector |

## Verification
The bench builds the block with NUM_SRC=12 and NUM_CTX=3. With these values the ID codes 12 to 15 and the context code 3 fit in the strobe fields but name nothing, so the bench can drive those ignored encodings. It sweeps every source, including source 0, through the full life cycle in both source types, with two contexts enabled and one disabled. It also hits enable resampling on a high line, and it lines up a claim with a new edge event in the same clock cycle.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

  typedef struct packed {
    logic pend;
    logic clm;
    logic tag;   // one-shot: claim removes the source entirely
  } gw_bits_t;

  // Next state of one source in one context; earlier branches take precedence.
  function automatic gw_bits_t gw_step(
    gw_bits_t cur,
    logic     en,
    logic     en_rise,
    logic     lvl,
    logic     is_edge,
    logic     assert_ev,
    logic     drop_ev,
    logic     claim_hit,
    logic     done_hit
  );
    gw_bits_t nxt;
    nxt = cur;
    if (!en) begin
      nxt = '0;
    end else if (assert_ev) begin
      nxt.pend = 1'b1;
      if (is_edge) nxt.tag = 1'b1;
    end else if (drop_ev) begin
      nxt = '0;
    end else if (en_rise && lvl) begin
      nxt.pend = 1'b1;
      nxt.tag  = is_edge;
    end else if (claim_hit && cur.pend) begin
      if (cur.tag) nxt = '0;
      else         nxt.clm = 1'b1;
    end
    if (done_hit) nxt.clm = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/irq_gw_input.sv
module irq_gw_input #(
  parameter int NUM_SRC     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] is_edge_i,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] assert_o,
  output logic [NUM_SRC-1:0] drop_o
);

  localparam logic [NUM_SRC-1:0] LIVE_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

  logic [NUM_SRC-1:0] stage_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] sync_lvl;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= src_i;
      for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_lvl = stage_q[SYNC_STAGES-1] & LIVE_MASK;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= sync_lvl;
  end

  assign lvl_o    = sync_lvl;
  assign assert_o = sync_lvl & ~prev_q;
  assign drop_o   = ~sync_lvl & prev_q & ~is_edge_i;

endmodule

// File: rtl/irq_gw_ctx.sv
module irq_gw_ctx
  import irq_gw_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int NUM_CTX = 4,
  parameter int CTX_IDX = 0,
  parameter int ID_W    = 5,
  parameter int CTX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] assert_i,
  input  logic [NUM_SRC-1:0] drop_i,
  input  logic [NUM_SRC-1:0] is_edge_i,
  input  logic               claim_valid_i,
  input  logic [CTX_W-1:0]   claim_ctx_i,
  input  logic [ID_W-1:0]    claim_id_i,
  input  logic               done_valid_i,
  input  logic [CTX_W-1:0]   done_ctx_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] clm_o
);

  logic [NUM_SRC-1:0] en_q;
  logic               claim_sel;
  logic               done_sel;

  always_ff @(posedge clk_i) begin
    if (rst_i) en_q <= '0;
    else       en_q <= en_i;
  end

  assign claim_sel = claim_valid_i && (claim_ctx_i == CTX_W'(CTX_IDX)) &&
                     (claim_id_i != '0) && (int'(claim_id_i) < NUM_SRC);
  assign done_sel  = done_valid_i && (done_ctx_i == CTX_W'(CTX_IDX)) &&
                     (done_id_i != '0) && (int'(done_id_i) < NUM_SRC);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_none
      logic unused_src0;
      assign unused_src0 = ^{en_i[0], en_q[0], lvl_i[0], assert_i[0],
                             drop_i[0], is_edge_i[0]};
      assign pend_o[0] = 1'b0;
      assign clm_o[0]  = 1'b0;
    end else begin : g_live
      gw_bits_t st_q;
      logic     claim_hit;
      logic     done_hit;

      assign claim_hit = claim_sel && (claim_id_i == ID_W'(s));
      assign done_hit  = done_sel  && (done_id_i  == ID_W'(s));

      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          st_q <= '0;
        end else begin
          st_q <= gw_step(st_q, en_i[s], en_i[s] & ~en_q[s], lvl_i[s],
                          is_edge_i[s], assert_i[s], drop_i[s],
                          claim_hit, done_hit);
        end
      end

      assign pend_o[s] = st_q.pend;
      assign clm_o[s]  = st_q.clm;
    end
  end

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int  NUM_SRC     = 24,
  parameter int  NUM_CTX     = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int ID_W        = $clog2(NUM_SRC),
  localparam int CTX_W       = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TOT         = NUM_CTX * NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] src_edge_i,
  input  logic [TOT-1:0]     enable_i,
  input  logic               claim_valid_i,
  input  logic [CTX_W-1:0]   claim_ctx_i,
  input  logic [ID_W-1:0]    claim_id_i,
  input  logic               done_valid_i,
  input  logic [CTX_W-1:0]   done_ctx_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [TOT-1:0]     pending_o,
  output logic [TOT-1:0]     claimed_o
);

  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] assert_ev;
  logic [NUM_SRC-1:0] drop_ev;

  irq_gw_input #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_input (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .src_i    (src_i),
    .is_edge_i(src_edge_i),
    .lvl_o    (lvl),
    .assert_o (assert_ev),
    .drop_o   (drop_ev)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_gw_ctx #(
      .NUM_SRC(NUM_SRC),
      .NUM_CTX(NUM_CTX),
      .CTX_IDX(c),
      .ID_W   (ID_W),
      .CTX_W  (CTX_W)
    ) u_ctx (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .en_i         (enable_i[c*NUM_SRC +: NUM_SRC]),
      .lvl_i        (lvl),
      .assert_i     (assert_ev),
      .drop_i       (drop_ev),
      .is_edge_i    (src_edge_i),
      .claim_valid_i(claim_valid_i),
      .claim_ctx_i  (claim_ctx_i),
      .claim_id_i   (claim_id_i),
      .done_valid_i (done_valid_i),
      .done_ctx_i   (done_ctx_i),
      .done_id_i    (done_id_i),
      .pend_o       (pending_o[c*NUM_SRC +: NUM_SRC]),
      .clm_o        (claimed_o[c*NUM_SRC +: NUM_SRC])
    );
  end

endmodule

// File: rtl/irq_gateway_chk.sv
module irq_gateway_chk #(
  parameter int NUM_SRC = 24,
  parameter int NUM_CTX = 4,
  parameter int ID_W    = 5,
  parameter int CTX_W   = 2
) (
  input logic                       clk_i,
  input logic                       rst_i,
  input logic [NUM_CTX*NUM_SRC-1:0] enable_i,
  input logic                       done_valid_i,
  input logic [CTX_W-1:0]           done_ctx_i,
  input logic [ID_W-1:0]            done_id_i,
  input logic [NUM_CTX*NUM_SRC-1:0] pending_o,
  input logic [NUM_CTX*NUM_SRC-1:0] claimed_o
);

  localparam int TOT = NUM_CTX * NUM_SRC;

  function automatic logic [TOT-1:0] src0_mask();
    logic [TOT-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CTX; c++) m[c*NUM_SRC] = 1'b1;
    return m;
  endfunction

  localparam logic [TOT-1:0] SRC0_MASK = src0_mask();

  // R12
  claimed_within_pending_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (claimed_o & ~pending_o) == '0);

  // R10
  source_zero_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pending_o | claimed_o) & SRC0_MASK) == '0);

  // R9
  disabled_state_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_valid_i || done_valid_i |=> ((pending_o | claimed_o) & ~$past(enable_i)) == '0);

  // R7
  done_clears_claimed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_valid_i && int'(done_ctx_i) < NUM_CTX && int'(done_id_i) < NUM_SRC)
    |=> !claimed_o[int'($past(done_ctx_i))*NUM_SRC + int'($past(done_id_i))]);

endmodule

bind irq_gateway irq_gateway_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_CTX(NUM_CTX),
  .ID_W   (ID_W),
  .CTX_W  (CTX_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .enable_i    (enable_i),
  .done_valid_i(done_valid_i),
  .done_ctx_i  (done_ctx_i),
  .done_id_i   (done_id_i),
  .pending_o   (pending_o),
  .claimed_o   (claimed_o)
);

// File: tb/irq_gateway_tb_top.sv
module irq_gateway_tb_top;

  localparam int NS  = 12;
  localparam int NC  = 3;
  localparam int IW  = $clog2(NS);
  localparam int CW  = (NC > 1) ? $clog2(NC) : 1;
  localparam int TOT = NS * NC;

  logic           clk = 1'b0;
  logic           rst;
  logic [NS-1:0]  src;
  logic [NS-1:0]  is_edge;
  logic [TOT-1:0] en;
  logic           claim_valid;
  logic [CW-1:0]  claim_ctx;
  logic [IW-1:0]  claim_id;
  logic           done_valid;
  logic [CW-1:0]  done_ctx;
  logic [IW-1:0]  done_id;
  logic [TOT-1:0] pending;
  logic [TOT-1:0] claimed;

  int checks = 0;
  int fails  = 0;

  bit m_pend [NC][NS];
  bit m_clm  [NC][NS];
  bit m_tag  [NC][NS];
  bit m_en   [NC][NS];
  bit m_lvl  [NS];

  always #5 clk = ~clk;

  irq_gateway #(.NUM_SRC(NS), .NUM_CTX(NC), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_i(rst), .src_i(src), .src_edge_i(is_edge),
    .enable_i(en), .claim_valid_i(claim_valid), .claim_ctx_i(claim_ctx),
    .claim_id_i(claim_id), .done_valid_i(done_valid), .done_ctx_i(done_ctx),
    .done_id_i(done_id), .pending_o(pending), .claimed_o(claimed)
  );

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req);
    logic [TOT-1:0] ep, ec;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) begin
        ep[c*NS+s] = m_pend[c][s];
        ec[c*NS+s] = m_clm[c][s];
      end
    checks++;
    if (pending !== ep || claimed !== ec) begin
      fails++;
      $display("FAIL %s pending=%h/%h claimed=%h/%h (actual/expected)",
               req, pending, ep, claimed, ec);
    end
  endtask

  function automatic void wipe(int c, int s);
    m_pend[c][s] = 0; m_clm[c][s] = 0; m_tag[c][s] = 0;
  endfunction

  task automatic do_src(int s, bit v);
    if (s != 0 && v != m_lvl[s]) begin
      for (int c = 0; c < NC; c++) begin
        if (v && m_en[c][s]) begin
          m_pend[c][s] = 1;
          if (is_edge[s]) m_tag[c][s] = 1;
        end else if (!v && !is_edge[s]) wipe(c, s);
      end
    end
    m_lvl[s] = v;
    src[s] = v;
    settle();
  endtask

  task automatic do_en(int c, int s, bit v);
    if (s != 0) begin
      if (!v) wipe(c, s);
      else if (!m_en[c][s] && m_lvl[s]) begin
        m_pend[c][s] = 1;
        m_tag[c][s]  = is_edge[s];
      end
    end
    m_en[c][s] = v;
    en[c*NS+s] = v;
    settle();
  endtask

  function automatic void model_claim(int c, int id);
    if (c < NC && id != 0 && id < NS && m_pend[c][id]) begin
      if (m_tag[c][id]) wipe(c, id);
      else m_clm[c][id] = 1;
    end
  endfunction

  task automatic do_claim(int c, int id);
    model_claim(c, id);
    claim_valid = 1'b1; claim_ctx = CW'(c); claim_id = IW'(id);
    @(posedge clk);
    @(negedge clk);
    claim_valid = 1'b0;
    settle();
  endtask

  task automatic do_done(int c, int id);
    if (c < NC && id != 0 && id < NS) m_clm[c][id] = 0;
    done_valid = 1'b1; done_ctx = CW'(c); done_id = IW'(id);
    @(posedge clk);
    @(negedge clk);
    done_valid = 1'b0;
    settle();
  endtask

  initial begin
    rst = 1'b1; src = '0; is_edge = '0; en = '0;
    claim_valid = 1'b0; claim_ctx = '0; claim_id = '0;
    done_valid = 1'b0; done_ctx = '0; done_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1");

    // Full life cycle per source, level sweep then edge sweep
    for (int ty = 0; ty < 2; ty++) begin
      is_edge = ty ? '1 : '0;
      for (int s = 0; s < NS; s++) begin
        do_en(0, s, 1); do_en(1, s, 1);
        check("R8");
        do_src(s, 1);
        check(s == 0 ? "R10" : (ty ? "R3" : "R2"));
        do_claim(0, s);
        check(ty ? "R6" : "R5");
        do_claim(0, s);
        check(ty ? "R3" : "R5");
        do_done(0, s);
        check("R7");
        do_claim(1, s);
        check(ty ? "R6" : "R5");
        do_src(s, 0);
        check("R4");
        do_en(0, s, 0); do_en(1, s, 0);
        check("R9");
      end
    end

    // Mixed types: odd sources edge, even level
    is_edge = 12'b1010_1010_1010;
    do_src(3, 1); do_src(4, 1);
    check("R9");
    do_en(2, 3, 1);
    check("R8");
    do_en(2, 4, 1);
    check("R8");
    do_claim(2, 3);
    check("R6");
    do_claim(2, 4);
    check("R5");
    do_en(2, 4, 0);
    check("R9");
    do_src(3, 0);
    check("R4");
    do_src(4, 0);
    check("R4");

    // Ignored encodings
    do_en(1, 5, 1);
    do_src(5, 1);
    check("R3");
    do_claim(3, 5);
    check("R10");
    do_claim(1, 0);
    do_claim(1, 13);
    do_claim(1, 15);
    check("R10");
    do_done(3, 5); do_done(1, 14);
    check("R10");
    do_en(1, 0, 1);
    do_src(0, 1);
    check("R10");
    do_claim(1, 6);
    check("R10");

    // Claim meets a fresh edge of the same source in one cycle
    do_en(1, 7, 1);
    do_src(7, 1);
    do_src(7, 0);
    check("R3");
    src[7] = 1'b1;
    m_lvl[7] = 1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    claim_valid = 1'b1; claim_ctx = CW'(1); claim_id = IW'(7);
    @(posedge clk);
    @(negedge clk);
    claim_valid = 1'b0;
    settle();
    check("R11");
    do_claim(1, 7);
    check("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule